// File: doc/BRIEF.md
# Receive Frame Length Policer

This block sits in an Ethernet receive path directly behind the frame-check stage. It accepts a byte-wide frame stream with valid, start and end markers. A flag that qualifies the frame check sequence comes with the final byte. The block then enforces the per-frame receive policy. Frames that arrive while the block is disabled, or that are too short to be real traffic, are discarded completely. Frames longer than the configured ceiling are cut at exactly that length. When stripping is enabled, the four trailing check bytes are removed. Frames that break the length rules or carry a bad check sequence are delivered with an error flag on their final beat, unless check-sequence errors are being ignored.

All policy inputs are captured on the first byte of each frame. A change made while a frame is in flight therefore only applies from the next frame onward. Every byte travels through a fixed-depth delay line. By the time a frame's opening bytes reach the output, the frame's end is already known, and each byte can be kept, killed or marked as the new final byte. Input frames must be presented with no idle cycles between their first and last byte. Gaps between frames are free.

Top module: `rx_len_policer`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid`, `out_sop`, `out_eop`, `out_err` and `out_trunc` are all low.
- R2: A frame of at least 16 bytes and at most the maximum length is delivered byte for byte, unchanged, when stripping is off and no rule is broken. `out_sop` is on its first byte, `out_eop` on its last, and `out_err` stays low. A byte sampled on a rising edge is presented 15 rising edges later.
- R3: With stripping on, a frame longer than 8 bytes loses its last 4 bytes. `out_eop` and any error then sit on the new final byte.
- R4: With ignore-check off, a frame whose `in_fcs_bad` is high on its end beat is delivered with `out_err` high on its final output beat only.
- R5: With ignore-check on, a bad check sequence alone leaves `out_err` low.
- R6: A frame longer than `cfg_max_len` is delivered as exactly `cfg_max_len` bytes and is never stripped. `out_eop`, `out_err` and a one-cycle `out_trunc` all fall on that last byte. The rest of the input frame is discarded. A frame of exactly `cfg_max_len` bytes is not truncated.
- R7: A frame shorter than 16 bytes produces no output beat at all. A 16-byte frame is delivered.
- R8: A frame whose received length, counted before stripping, is below `cfg_min_len` carries `out_err` on its final beat. A frame of exactly `cfg_min_len` bytes does not.
- R9: A frame whose first byte arrives while `cfg_enable` is low produces no output. Lowering `cfg_enable` in the middle of a frame lets that frame finish whole.
- R10: `cfg_strip_fcs`, `cfg_ignore_fcs`, `cfg_max_len` and `cfg_min_len` are taken from the first byte's cycle. Changing them mid-frame does not alter that frame.
- R11: A frame of 8 bytes or fewer keeps its check bytes even with stripping on. This is observable when the drop threshold parameter is set below 9.
- R12: Output frames are well formed. Each starts with `out_sop`, continues on consecutive cycles without a second `out_sop`, and ends with `out_eop`. No valid beat appears between frames without `out_sop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| in_fcs_bad | input | 1 | Check sequence failed; meaningful on the end beat |
| cfg_enable | input | 1 | Accept new frames |
| cfg_strip_fcs | input | 1 | Remove the trailing 4 check bytes |
| cfg_ignore_fcs | input | 1 | Do not flag check-sequence errors |
| cfg_max_len | input | 15 | Length ceiling, legal 64 to 16383, top bit zero |
| cfg_min_len | input | 8 | Length floor for the undersize error |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First output byte of a frame |
| out_eop | output | 1 | Last output byte of a frame |
| out_data | output | 8 | Output byte |
| out_err | output | 1 | Frame error, on the final beat only |
| out_trunc | output | 1 | One-cycle pulse on the final beat of a truncated frame |

## Verification
The bound checker watches, on every cycle, that errors and truncation pulses appear only on a final beat. It also checks that output frames open with a start marker and run contiguously to their end, and that the outputs are quiet coming out of reset. Which bytes survive cannot be seen on a single cycle, and neither can the moment a frame is cut, the four stripped bytes, the drop of short frames, or the capture of policy at the first byte. Only the bench's scenarios show these, by comparing whole output streams against frames predicted from the requirements. A second instance with a low drop threshold exposes the rule that keeps the check bytes on very short frames.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    localparam int LEN_W  = 15;
    localparam int DATA_W = 8;
    localparam int MIN_W  = 8;
    localparam int CNT_W  = LEN_W + 1;

    typedef enum logic [1:0] {
        ING_IDLE = 2'd0,
        ING_PASS = 2'd1,
        ING_SKIP = 2'd2
    } ing_state_e;

    // One byte slot travelling through the delay line.
    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              last;
        logic              err;
        logic              trunc;
        logic              live;   // belongs to the frame still arriving
        logic [LEN_W-1:0]  idx;    // byte position inside its frame
        logic [DATA_W-1:0] data;
    } beat_t;

    // Produced on the cycle a frame's length becomes known.
    typedef struct packed {
        logic             fire;
        logic             trunc;
        logic             fcs_bad;
        logic             strip;
        logic             ignore;
        logic [LEN_W-1:0] n;
        logic [MIN_W-1:0] min_len;
    } frame_end_t;

    // Decision broadcast to every live slot.
    typedef struct packed {
        logic             fire;
        logic             drop;
        logic             err;
        logic             trunc;
        logic [LEN_W-1:0] keep;
    } verdict_t;

    function automatic beat_t adjudicate(input beat_t b, input verdict_t v);
        beat_t r;
        r = b;
        if (v.fire && b.live) begin
            r.live = 1'b0;
            if (v.drop || (b.idx >= v.keep)) begin
                r.vld = 1'b0;
            end else if ((CNT_W'(b.idx) + CNT_W'(1)) == CNT_W'(v.keep)) begin
                r.last  = 1'b1;
                r.err   = v.err;
                r.trunc = v.trunc;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rxpol_ingress.sv
module rxpol_ingress
    import rxpol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_fcs_bad,
    input  logic              cfg_enable,
    input  logic              cfg_strip_fcs,
    input  logic              cfg_ignore_fcs,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [MIN_W-1:0]  cfg_min_len,
    output beat_t             new_beat,
    output frame_end_t        fin
);

    ing_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] max_q;
    logic [MIN_W-1:0] min_q;
    logic             strip_q;
    logic             ignore_q;

    logic             take;
    logic             hit_max;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] eff_max;
    logic [CNT_W-1:0] pos;

    always_comb begin
        take    = in_valid && (in_sop ? cfg_enable : (state_q == ING_PASS));
        idx     = in_sop ? '0 : cnt_q;
        eff_max = in_sop ? cfg_max_len : max_q;
        pos     = CNT_W'(idx) + CNT_W'(1);
        hit_max = take && !in_eop && (pos == CNT_W'(eff_max));

        fin.fire    = take && (in_eop || hit_max);
        fin.trunc   = hit_max;
        fin.fcs_bad = in_fcs_bad && in_eop;
        fin.strip   = in_sop ? cfg_strip_fcs  : strip_q;
        fin.ignore  = in_sop ? cfg_ignore_fcs : ignore_q;
        fin.min_len = in_sop ? cfg_min_len    : min_q;
        fin.n       = pos[LEN_W-1:0];

        new_beat.vld   = take;
        new_beat.sop   = take && in_sop;
        new_beat.last  = 1'b0;
        new_beat.err   = 1'b0;
        new_beat.trunc = 1'b0;
        new_beat.live  = take;
        new_beat.idx   = idx;
        new_beat.data  = in_data;

        state_d = state_q;
        if (take) begin
            if (hit_max)     state_d = ING_SKIP;
            else if (in_eop) state_d = ING_IDLE;
            else             state_d = ING_PASS;
        end else if (in_valid && in_sop) begin
            state_d = in_eop ? ING_IDLE : ING_SKIP;
        end else if (in_valid && in_eop && (state_q == ING_SKIP)) begin
            state_d = ING_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ING_IDLE;
            cnt_q    <= '0;
            max_q    <= '0;
            min_q    <= '0;
            strip_q  <= 1'b0;
            ignore_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cnt_q <= pos[LEN_W-1:0];
            end
            if (take && in_sop) begin
                max_q    <= cfg_max_len;
                min_q    <= cfg_min_len;
                strip_q  <= cfg_strip_fcs;
                ignore_q <= cfg_ignore_fcs;
            end
        end
    end

endmodule

// File: rtl/rxpol_verdict.sv
module rxpol_verdict
    import rxpol_pkg::*;
#(
    parameter int DROP_BELOW    = 16,
    parameter int FCS_BYTES     = 4,
    parameter int KEEP_FCS_UPTO = 8
) (
    input  frame_end_t fin,
    output verdict_t   v
);

    logic strip_eff;
    logic undersize;

    always_comb begin
        strip_eff = fin.strip && !fin.trunc && (fin.n > LEN_W'(KEEP_FCS_UPTO));
        undersize = !fin.trunc && (fin.n < LEN_W'(fin.min_len));
        v.fire    = fin.fire;
        v.drop    = fin.n < LEN_W'(DROP_BELOW);
        v.trunc   = fin.trunc;
        v.err     = fin.trunc || undersize || (fin.fcs_bad && !fin.ignore);
        v.keep    = strip_eff ? (fin.n - LEN_W'(FCS_BYTES)) : fin.n;
    end

endmodule

// File: rtl/rxpol_delay.sv
module rxpol_delay
    import rxpol_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             new_beat,
    input  verdict_t          v,
    output logic              q_valid,
    output logic              q_sop,
    output logic              q_eop,
    output logic [DATA_W-1:0] q_data,
    output logic              q_err,
    output logic              q_trunc
);

    beat_t st [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st[i] <= '0;
            end
        end else begin
            st[0] <= adjudicate(new_beat, v);
            for (int i = 1; i < DEPTH; i++) begin
                st[i] <= adjudicate(st[i-1], v);
            end
        end
    end

    always_comb begin
        q_valid = st[DEPTH-1].vld;
        q_sop   = st[DEPTH-1].vld && st[DEPTH-1].sop;
        q_eop   = st[DEPTH-1].vld && st[DEPTH-1].last;
        q_err   = st[DEPTH-1].vld && st[DEPTH-1].last && st[DEPTH-1].err;
        q_trunc = st[DEPTH-1].vld && st[DEPTH-1].last && st[DEPTH-1].trunc;
        q_data  = st[DEPTH-1].data;
    end

endmodule

// File: rtl/rx_len_policer.sv
module rx_len_policer
    import rxpol_pkg::*;
#(
    parameter int DROP_BELOW    = 16,
    parameter int FCS_BYTES     = 4,
    parameter int KEEP_FCS_UPTO = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_fcs_bad,
    input  logic              cfg_enable,
    input  logic              cfg_strip_fcs,
    input  logic              cfg_ignore_fcs,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [MIN_W-1:0]  cfg_min_len,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err,
    output logic              out_trunc
);

    // The line must hold a whole droppable frame and the stripped tail.
    localparam int DEPTH = (DROP_BELOW > FCS_BYTES + 1) ? DROP_BELOW : FCS_BYTES + 1;

    beat_t      new_beat;
    frame_end_t fin;
    verdict_t   v;

    rxpol_ingress u_ingress (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_sop         (in_sop),
        .in_eop         (in_eop),
        .in_data        (in_data),
        .in_fcs_bad     (in_fcs_bad),
        .cfg_enable     (cfg_enable),
        .cfg_strip_fcs  (cfg_strip_fcs),
        .cfg_ignore_fcs (cfg_ignore_fcs),
        .cfg_max_len    (cfg_max_len),
        .cfg_min_len    (cfg_min_len),
        .new_beat       (new_beat),
        .fin            (fin)
    );

    rxpol_verdict #(
        .DROP_BELOW    (DROP_BELOW),
        .FCS_BYTES     (FCS_BYTES),
        .KEEP_FCS_UPTO (KEEP_FCS_UPTO)
    ) u_verdict (
        .fin (fin),
        .v   (v)
    );

    rxpol_delay #(
        .DEPTH (DEPTH)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .new_beat (new_beat),
        .v        (v),
        .q_valid  (out_valid),
        .q_sop    (out_sop),
        .q_eop    (out_eop),
        .q_data   (out_data),
        .q_err    (out_err),
        .q_trunc  (out_trunc)
    );

endmodule

// File: rtl/rx_len_policer_chk.sv
module rx_len_policer_chk (
    input logic clk,
    input logic rst,
    input logic out_valid,
    input logic out_sop,
    input logic out_eop,
    input logic out_err,
    input logic out_trunc
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (out_valid) begin
            open_q <= !out_eop;
        end
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !out_trunc && !out_err));

    // R4
    err_on_final_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_eop));

    // R6
    trunc_on_final_chk: assert property (@(posedge clk) disable iff (rst)
        out_trunc |-> (out_valid && out_eop && out_err));

    // R12
    body_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |=> (out_valid && !out_sop));

    // R12
    opens_with_sop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !open_q) |-> out_sop);

endmodule

bind rx_len_policer rx_len_policer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_trunc (out_trunc)
);

// File: tb/rx_len_policer_tb.sv
module rx_len_policer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_fcs_bad = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cfg_enable = 1'b1, cfg_strip_fcs = 1'b0, cfg_ignore_fcs = 1'b0;
    logic [14:0] cfg_max_len = 15'd1518;
    logic [7:0]  cfg_min_len = 8'd64;

    logic       o_valid, o_sop, o_eop, o_err, o_trunc;
    logic [7:0] o_data;
    logic       l_valid, l_sop, l_eop, l_err, l_trunc;
    logic [7:0] l_data;

    int n_checks = 0;
    int n_fail   = 0;
    int stray    = 0;

    logic [7:0]  fbuf [0:511];
    logic [11:0] exp_q[$], obs_q[$], exp_l[$], obs_l[$];

    always #10 clk = ~clk;

    rx_len_policer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_fcs_bad(in_fcs_bad), .cfg_enable(cfg_enable),
        .cfg_strip_fcs(cfg_strip_fcs), .cfg_ignore_fcs(cfg_ignore_fcs),
        .cfg_max_len(cfg_max_len), .cfg_min_len(cfg_min_len),
        .out_valid(o_valid), .out_sop(o_sop), .out_eop(o_eop), .out_data(o_data),
        .out_err(o_err), .out_trunc(o_trunc)
    );

    rx_len_policer #(.DROP_BELOW(1)) u_dut_lo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_fcs_bad(in_fcs_bad), .cfg_enable(cfg_enable),
        .cfg_strip_fcs(cfg_strip_fcs), .cfg_ignore_fcs(cfg_ignore_fcs),
        .cfg_max_len(cfg_max_len), .cfg_min_len(cfg_min_len),
        .out_valid(l_valid), .out_sop(l_sop), .out_eop(l_eop), .out_data(l_data),
        .out_err(l_err), .out_trunc(l_trunc)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (o_valid) obs_q.push_back({o_trunc, o_sop, o_eop, o_err, o_data});
            if (l_valid) obs_l.push_back({l_trunc, l_sop, l_eop, l_err, l_data});
            if ((o_trunc && !(o_valid && o_eop)) || (l_trunc && !(l_valid && l_eop))) stray++;
        end
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Expected output of one frame, from the requirements and the policy at its first byte.
    task automatic expect_frame(input int len, input bit bad, input int thr, input bit lo);
        bit tr, strip_now, err;
        int n, keep;
        logic [11:0] w;
        if (!cfg_enable) return;
        tr = (len > int'(cfg_max_len));
        n  = tr ? int'(cfg_max_len) : len;
        if (n < thr) return;
        strip_now = cfg_strip_fcs && !tr && (n > 8);
        keep = strip_now ? n - 4 : n;
        err  = tr || (!tr && n < int'(cfg_min_len)) || (bad && !cfg_ignore_fcs);
        for (int i = 0; i < keep; i++) begin
            w = {(tr && i == keep-1), (i == 0), (i == keep-1), (err && i == keep-1), fbuf[i]};
            if (lo) exp_l.push_back(w);
            else    exp_q.push_back(w);
        end
    endtask

    task automatic send_frame(input int len, input bit bad, input int gap, input int mid);
        for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
        expect_frame(len, bad, 16, 1'b0);
        expect_frame(len, bad, 1, 1'b1);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 1 && mid[0]) cfg_strip_fcs = !cfg_strip_fcs;
            if (i == 1 && mid[1]) cfg_enable = 1'b0;
            in_valid   = 1'b1;
            in_sop     = (i == 0);
            in_eop     = (i == len-1);
            in_data    = fbuf[i];
            in_fcs_bad = bad && (i == len-1);
        end
        if (gap > 0) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fcs_bad = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic check_stream(input string tag);
        int ne, no, at;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fcs_bad = 1'b0;
        repeat (24) @(negedge clk);
        ne = exp_q.size(); no = obs_q.size(); at = -1;
        if (ne == no) for (int i = 0; i < ne; i++) if (at < 0 && exp_q[i] !== obs_q[i]) at = i;
        n_checks++;
        if (ne != no) begin
            n_fail++;
            $display("FAIL %s: beats actual=%0d expected=%0d", tag, no, ne);
        end else if (at >= 0) begin
            n_fail++;
            $display("FAIL %s: beat %0d actual=%h expected=%h", tag, at, obs_q[at], exp_q[at]);
        end
        ne = exp_l.size(); no = obs_l.size(); at = -1;
        if (ne == no) for (int i = 0; i < ne; i++) if (at < 0 && exp_l[i] !== obs_l[i]) at = i;
        n_checks++;
        if (ne != no) begin
            n_fail++;
            $display("FAIL %s (low threshold): beats actual=%0d expected=%0d", tag, no, ne);
        end else if (at >= 0) begin
            n_fail++;
            $display("FAIL %s (low threshold): beat %0d actual=%h expected=%h", tag, at, obs_l[at], exp_l[at]);
        end
        exp_q.delete(); obs_q.delete(); exp_l.delete(); obs_l.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        void'($urandom(32'd20240611));

        // R1: quiet in and just after reset
        repeat (4) @(negedge clk);
        chk(!o_valid && !o_trunc && !o_err && !l_valid, "R1 outputs during reset", int'(o_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!o_valid && !o_trunc && !o_err && !l_valid, "R1 outputs after reset", int'(o_valid), 0);

        // R2: latency and pass-through
        lat = 0;
        fork
            send_frame(64, 1'b0, 1, 0);
            begin
                do @(posedge clk); while (!(in_valid && in_sop));
                while (lat < 100) begin
                    @(negedge clk);
                    if (o_valid && o_sop) break;
                    @(posedge clk);
                    lat++;
                end
            end
        join
        chk(lat == 15, "R2 latency in edges", lat, 15);
        send_frame(200, 1'b0, 2, 0);
        check_stream("R2 pass-through frames");

        // R3: stripping
        cfg_strip_fcs = 1'b1;
        send_frame(64, 1'b0, 1, 0);
        send_frame(16, 1'b1, 1, 0);
        check_stream("R3 strip four bytes");
        cfg_strip_fcs = 1'b0;

        // R4 / R5: check-sequence errors
        send_frame(80, 1'b1, 1, 0);
        check_stream("R4 bad check flagged");
        cfg_ignore_fcs = 1'b1;
        send_frame(80, 1'b1, 1, 0);
        check_stream("R5 bad check ignored");
        cfg_ignore_fcs = 1'b0;

        // R6: truncation at the ceiling
        cfg_max_len = 15'd64;
        send_frame(100, 1'b0, 1, 0);
        send_frame(64, 1'b0, 1, 0);
        send_frame(65, 1'b1, 0, 0);
        cfg_strip_fcs = 1'b1;
        send_frame(90, 1'b0, 1, 0);
        check_stream("R6 truncation");
        cfg_strip_fcs = 1'b0;
        cfg_max_len = 15'd1518;

        // R7: runt drop, back to back
        send_frame(15, 1'b0, 0, 0);
        send_frame(16, 1'b0, 0, 0);
        send_frame(1, 1'b0, 0, 0);
        send_frame(15, 1'b0, 1, 0);
        check_stream("R7 short frames dropped");

        // R8: undersize error
        cfg_min_len = 8'd100;
        send_frame(99, 1'b0, 1, 0);
        send_frame(100, 1'b0, 1, 0);
        check_stream("R8 undersize flag");
        cfg_min_len = 8'd64;

        // R9: enable handling
        cfg_enable = 1'b0;
        send_frame(70, 1'b0, 1, 0);
        check_stream("R9 disabled frame dropped");
        cfg_enable = 1'b1;
        send_frame(70, 1'b0, 1, 2);
        send_frame(40, 1'b0, 1, 0);
        cfg_enable = 1'b1;
        send_frame(40, 1'b0, 1, 0);
        check_stream("R9 mid-frame disable finishes frame");

        // R10: policy captured at first byte
        cfg_strip_fcs = 1'b0;
        send_frame(50, 1'b0, 1, 1);
        send_frame(50, 1'b0, 1, 1);
        check_stream("R10 strip change mid-frame");
        cfg_strip_fcs = 1'b0;

        // R11: very short frames keep their check bytes
        cfg_strip_fcs = 1'b1;
        send_frame(8, 1'b0, 1, 0);
        send_frame(9, 1'b0, 1, 0);
        send_frame(5, 1'b1, 1, 0);
        check_stream("R11 short frame keeps check bytes");
        cfg_strip_fcs = 1'b0;

        // Mixed random traffic: R2 R3 R4 R6 R7 R8 R12
        for (int f = 0; f < 80; f++) begin
            cfg_enable     = (($urandom % 10) != 0);
            cfg_strip_fcs  = 1'($urandom % 2);
            cfg_ignore_fcs = 1'($urandom % 2);
            cfg_max_len    = 15'(64 + $urandom % 100);
            cfg_min_len    = 8'($urandom % 120);
            send_frame(1 + int'($urandom % 200), 1'($urandom % 2), int'($urandom % 3), 0);
            if (f % 10 == 9) check_stream("R12 random traffic batch");
        end

        chk(stray == 0, "R6 truncation pulse off final beat", stray, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule